// File: doc/BRIEF.md
# Multiplexed Bus Target Controller

This block is the responding side of a synchronous parallel bus on which one 32-bit set of lines carries first an address and then data, and on which four command lanes carry the transfer type in the first clock and active-low byte enables afterwards. It watches the active-low frame strobe to find the address clock, decides whether the access is meant for it, and then answers with device-select and target-ready. Read data goes out on its own output bus with a separate output enable that stands in for a tristate driver, and write data is captured from the input bus.

Two kinds of access are claimed. The first kind is I/O cycles that fall inside a 16-byte register window, whose base sits in configuration dword 4. The second kind is configuration cycles while the device's select input is high. A backend can stretch any data phase with a wait input, or end the transfer early with a stop request. A stop before any data has moved is a retry, and a stop after data has moved is a disconnect. The target also disconnects by itself when a burst would run past the last dword of the space it is addressing.

Top module: `busTgtTop`

## Requirements
- R1: After reset, device-select, target-ready and stop are high (inactive), the control-line enable `ctlOe` is 0 and the data enable `adOe` is 0.
- R2: An address clock with frame low, command 0010 (I/O read) or 0011 (I/O write), and `adIn[31:4]` equal to the window base makes device-select go low in the next clock. Any other address leaves the target silent. The byte address bits `adIn[3:0]` select a location inside the window, and `adIn[3:2]` is the first dword index.
- R3: Command 1010 (config read) or 1011 (config write) is claimed only when `idSel` is high and `adIn[1:0]` is 00 in the address clock. `adIn[7:2]` is the dword index.
- R4: A word moves only at a rising edge where `irdyN` and `trdyN` are both low. Once target-ready is low it stays low until that word has moved.
- R5: While `waitIn` is high, target-ready stays high. It goes low in the clock after the edge at which `waitIn` is first seen low.
- R6: On a write, `cbeN[i]` low enables byte i (bits 8i+7..8i). Bytes whose enable is high keep their old value.
- R7: The data phases of a burst address consecutive dwords, starting at the dword given in the address clock.
- R8: After the final phase (frame high with irdy low, and a word moved or stop asserted), device-select, target-ready and stop are driven high for one clock with `ctlOe` 1. After that clock `ctlOe` falls to 0.
- R9: A stop request makes stop go low with target-ready high in the next clock. Made before any word has moved, it ends the transfer with no data (retry). Made after a word has moved, it ends the transfer after that word (disconnect).
- R10: If the last dword of the addressed space (I/O dword 3, config dword 63) moves while frame is still low, the target asserts stop with target-ready high in the next clock.
- R11: Configuration dword 0 reads {device ID, vendor ID}. Dword 1 reads {16'h0000 status, 16-bit command register}. Dword 4 reads {base[31:4], 4'b0001}. Every other dword reads 0 and ignores writes.
- R12: `adOe` is 1 only during the data clocks of a claimed read, and never in the first clock after the address clock.
- R13: I/O cycles are claimed only while command register bit 0 is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rstN | input | 1 | Active-low reset |
| frameN | input | 1 | Active-low frame from the initiator |
| irdyN | input | 1 | Active-low initiator ready |
| idSel | input | 1 | Select for configuration cycles |
| cbeN | input | 4 | Command in the address clock, active-low byte enables in data clocks |
| adIn | input | 32 | Address/data lines as seen by the target |
| waitIn | input | 1 | Backend asks for wait states |
| stopReq | input | 1 | Backend asks to end the transfer early |
| adOut | output | 32 | Read data driven toward the address/data lines |
| adOe | output | 1 | Output enable for `adOut` |
| devselN | output | 1 | Active-low device select |
| trdyN | output | 1 | Active-low target ready |
| stopN | output | 1 | Active-low stop |
| ctlOe | output | 1 | Output enable for devselN, trdyN and stopN |

## Verification
The hardest case to reach is the end of the I/O window during a burst. The bench must first program the base and the enable bit through configuration writes. It then starts a write at dword 3 with frame held low for more phases, so the target has to break the burst by itself, with no stop request from the backend. Retry and disconnect come from the same stop request, so the bench raises it either at the first data clock or in the clock of a word transfer, and checks by read-back whether the register changed. Initiator stalls with target-ready already low are made by holding `irdyN` high for several clocks. This exercises the rule that target-ready must not drop back while a word is pending.

// File: rtl/busTgtPkg.sv
package busTgtPkg;

  // Command codes seen on the command lanes in the address clock
  localparam logic [3:0] CMD_IO_RD  = 4'b0010;
  localparam logic [3:0] CMD_IO_WR  = 4'b0011;
  localparam logic [3:0] CMD_CFG_RD = 4'b1010;
  localparam logic [3:0] CMD_CFG_WR = 4'b1011;

  typedef enum logic [1:0] {
    ST_IDLE,   // bus free, looking for an address clock
    ST_SKIP,   // someone else's transfer in progress
    ST_BUSY,   // claimed, data phases running
    ST_TURN    // driving control lines high one clock before release
  } tgtState_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic capAddr;   // latch address, space and direction
    logic doWrite;   // commit write data at current index
    logic advance;   // move to the next dword
    logic loadRead;  // load read register from next index
  } dpStrobe_t;

endpackage

// File: rtl/busTgtData.sv
module busTgtData
  import busTgtPkg::*;
#(
  parameter logic [15:0] VENDOR_ID  = 16'h1D0F,
  parameter logic [15:0] DEVICE_ID  = 16'hA53C,
  parameter int          IO_DWORDS  = 4,
  parameter int          CFG_DWORDS = 64
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic [31:0] adIn,
  input  logic [3:0]  cbeN,
  input  logic        idSel,
  input  dpStrobe_t   stb,
  output logic        hitNow,
  output logic        isReadNow,
  output logic        isRead,
  output logic        atEnd,
  output logic [31:0] adOut
);

  localparam int IO_IDX_W  = $clog2(IO_DWORDS);
  localparam int CFG_IDX_W = $clog2(CFG_DWORDS);
  localparam int IDX_W     = CFG_IDX_W;
  localparam int IO_LSB    = IO_IDX_W + 2;
  localparam logic [IO_IDX_W-1:0] IO_LAST  = IO_IDX_W'(IO_DWORDS - 1);
  localparam logic [IDX_W-1:0]    CFG_LAST = IDX_W'(CFG_DWORDS - 1);
  localparam logic [IDX_W-1:0]    ID_IDX   = IDX_W'(0);
  localparam logic [IDX_W-1:0]    CMD_IDX  = IDX_W'(1);
  localparam logic [IDX_W-1:0]    BASE_IDX = IDX_W'(4);

  logic [15:0]                  cmdReg;
  logic [31:IO_LSB]             baseReg;
  logic [IO_DWORDS-1:0][31:0]   ioRegs;
  logic                         spaceCfg;
  logic [IDX_W-1:0]             idx;
  logic [IDX_W-1:0]             idxNext;
  logic                         ioCmd;
  logic                         cfgCmd;
  logic                         ioHit;
  logic                         cfgHit;
  logic [31:0]                  curWord;
  logic [31:0]                  nextWord;
  logic [31:0]                  wrMerged;

  function automatic logic [31:0] rdWord(input logic cfg, input logic [IDX_W-1:0] i);
    logic [31:0] r;
    r = '0;
    if (cfg) begin
      if (i == ID_IDX)        r = {DEVICE_ID, VENDOR_ID};
      else if (i == CMD_IDX)  r = {16'h0000, cmdReg};
      else if (i == BASE_IDX) r = {baseReg, {(IO_LSB-1){1'b0}}, 1'b1};
    end else begin
      r = ioRegs[i[IO_IDX_W-1:0]];
    end
    return r;
  endfunction

  function automatic logic [31:0] mergeBytes(input logic [31:0] oldW,
                                             input logic [31:0] newW,
                                             input logic [3:0]  enN);
    logic [31:0] r;
    for (int b = 0; b < 4; b++)
      r[b*8 +: 8] = enN[b] ? oldW[b*8 +: 8] : newW[b*8 +: 8];
    return r;
  endfunction

  // Address decode in the address clock
  always_comb begin
    ioCmd     = (cbeN[3:1] == CMD_IO_RD[3:1]);
    cfgCmd    = (cbeN[3:1] == CMD_CFG_RD[3:1]);
    ioHit     = ioCmd && cmdReg[0] && (adIn[31:IO_LSB] == baseReg);
    cfgHit    = cfgCmd && idSel && (adIn[1:0] == 2'b00);
    hitNow    = ioHit || cfgHit;
    isReadNow = !cbeN[0];
  end

  always_comb begin
    idxNext  = stb.advance ? idx + IDX_W'(1) : idx;
    curWord  = rdWord(spaceCfg, idx);
    nextWord = rdWord(spaceCfg, idxNext);
    wrMerged = mergeBytes(curWord, adIn, cbeN);
    atEnd    = spaceCfg ? (idx == CFG_LAST) : (idx[IO_IDX_W-1:0] == IO_LAST);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cmdReg   <= '0;
      baseReg  <= '0;
      ioRegs   <= '0;
      spaceCfg <= 1'b0;
      isRead   <= 1'b0;
      idx      <= '0;
      adOut    <= '0;
    end else begin
      if (stb.capAddr) begin
        spaceCfg <= cfgCmd;
        isRead   <= isReadNow;
        idx      <= cfgCmd ? adIn[CFG_IDX_W+1:2] : IDX_W'(adIn[IO_LSB-1:2]);
      end else begin
        idx <= idxNext;
      end
      if (stb.doWrite) begin
        if (spaceCfg) begin
          if (idx == CMD_IDX)       cmdReg  <= wrMerged[15:0];
          else if (idx == BASE_IDX) baseReg <= wrMerged[31:IO_LSB];
        end else begin
          ioRegs[idx[IO_IDX_W-1:0]] <= wrMerged;
        end
      end
      if (stb.loadRead) adOut <= nextWord;
    end
  end

  // R6
  no_byte_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stb.doWrite && !spaceCfg && cbeN == 4'hF) |=> $stable(ioRegs));

  // R13
  io_enable_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stb.capAddr && !cbeN[3]) |-> cmdReg[0]);

  // R3
  cfg_select_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stb.capAddr && cbeN[3]) |-> (idSel && adIn[1:0] == 2'b00));

endmodule

// File: rtl/busTgtCtrl.sv
module busTgtCtrl
  import busTgtPkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      frameN,
  input  logic      irdyN,
  input  logic      waitIn,
  input  logic      stopReq,
  input  logic      hitNow,
  input  logic      isRead,
  input  logic      atEnd,
  output dpStrobe_t stb,
  output logic      devselN,
  output logic      trdyN,
  output logic      stopN,
  output logic      ctlOe,
  output logic      adOe
);

  tgtState_t state, stNext;
  logic frameQ;
  logic devNext, trdyNext, stopNext, ctlNext, adOeNext;
  logic addrPhase, xfer, finish, trdyHold;

  always_comb begin
    addrPhase = !frameN && frameQ;
    xfer      = (state == ST_BUSY) && !irdyN && !trdyN;
    finish    = (state == ST_BUSY) && !irdyN && frameN && (xfer || !stopN);
    trdyHold  = !trdyN && !xfer;
  end

  always_comb begin
    stNext   = state;
    devNext  = devselN;
    trdyNext = trdyN;
    stopNext = stopN;
    ctlNext  = ctlOe;
    adOeNext = adOe;
    stb      = '0;
    unique case (state)
      ST_IDLE, ST_TURN: begin
        stNext   = ST_IDLE;
        devNext  = 1'b1;
        trdyNext = 1'b1;
        stopNext = 1'b1;
        adOeNext = 1'b0;
        ctlNext  = 1'b0;
        if (addrPhase) begin
          if (hitNow) begin
            stNext      = ST_BUSY;
            devNext     = 1'b0;
            ctlNext     = 1'b1;
            stb.capAddr = 1'b1;
          end else begin
            stNext = ST_SKIP;
          end
        end
      end
      ST_SKIP: begin
        if (frameN && irdyN) stNext = ST_IDLE;
      end
      ST_BUSY: begin
        stb.advance = xfer;
        stb.doWrite = xfer && !isRead;
        if (finish) begin
          stNext   = ST_TURN;
          devNext  = 1'b1;
          trdyNext = 1'b1;
          stopNext = 1'b1;
          adOeNext = 1'b0;
        end else begin
          adOeNext = isRead;
          if (!stopN || trdyHold) begin
            // keep stop, or keep a pending ready until the word moves
          end else if ((xfer && atEnd) || stopReq) begin
            stopNext = 1'b0;
            trdyNext = 1'b1;
          end else begin
            trdyNext     = waitIn;
            stb.loadRead = 1'b1;
          end
        end
      end
      default: stNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      frameQ  <= 1'b1;
      devselN <= 1'b1;
      trdyN   <= 1'b1;
      stopN   <= 1'b1;
      ctlOe   <= 1'b0;
      adOe    <= 1'b0;
    end else begin
      state   <= stNext;
      frameQ  <= frameN;
      devselN <= devNext;
      trdyN   <= trdyNext;
      stopN   <= stopNext;
      ctlOe   <= ctlNext;
      adOe    <= adOeNext;
    end
  end

  // R4
  trdy_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!trdyN && irdyN) |=> !trdyN);

  // R9
  stop_no_trdy_chk: assert property (@(posedge clk) disable iff (!rstN)
    !stopN |-> trdyN);

  // R12
  ad_owner_chk: assert property (@(posedge clk) disable iff (!rstN)
    adOe |-> (!devselN && ctlOe));

  // R12
  turnaround_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(devselN) |-> !adOe);

  // R8
  release_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!devselN && !irdyN && frameN && (!trdyN || !stopN)) |=> (devselN && ctlOe));

  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !ctlOe |-> (devselN && trdyN && stopN));

endmodule

// File: rtl/busTgtTop.sv
module busTgtTop
  import busTgtPkg::*;
#(
  parameter logic [15:0] VENDOR_ID  = 16'h1D0F,
  parameter logic [15:0] DEVICE_ID  = 16'hA53C,
  parameter int          IO_DWORDS  = 4,
  parameter int          CFG_DWORDS = 64
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        frameN,
  input  logic        irdyN,
  input  logic        idSel,
  input  logic [3:0]  cbeN,
  input  logic [31:0] adIn,
  input  logic        waitIn,
  input  logic        stopReq,
  output logic [31:0] adOut,
  output logic        adOe,
  output logic        devselN,
  output logic        trdyN,
  output logic        stopN,
  output logic        ctlOe
);

  dpStrobe_t stb;
  logic hitNow, isReadNow, isRead, atEnd;

  busTgtData #(
    .VENDOR_ID (VENDOR_ID),
    .DEVICE_ID (DEVICE_ID),
    .IO_DWORDS (IO_DWORDS),
    .CFG_DWORDS(CFG_DWORDS)
  ) i_data (
    .clk      (clk),
    .rstN     (rstN),
    .adIn     (adIn),
    .cbeN     (cbeN),
    .idSel    (idSel),
    .stb      (stb),
    .hitNow   (hitNow),
    .isReadNow(isReadNow),
    .isRead   (isRead),
    .atEnd    (atEnd),
    .adOut    (adOut)
  );

  busTgtCtrl i_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .frameN (frameN),
    .irdyN  (irdyN),
    .waitIn (waitIn),
    .stopReq(stopReq),
    .hitNow (hitNow),
    .isRead (isRead),
    .atEnd  (atEnd),
    .stb    (stb),
    .devselN(devselN),
    .trdyN  (trdyN),
    .stopN  (stopN),
    .ctlOe  (ctlOe),
    .adOe   (adOe)
  );

endmodule

// File: tb/test_busTgtTop.sv
module test_busTgtTop;

  localparam logic [15:0] VEN = 16'h1D0F;
  localparam logic [15:0] DEV = 16'hA53C;

  logic        clk = 1'b0;
  logic        rstN;
  logic        frameN, irdyN, idSel, waitIn, stopReq;
  logic [3:0]  cbeN;
  logic [31:0] adIn;
  logic [31:0] adOut;
  logic        adOe, devselN, trdyN, stopN, ctlOe;

  int nChecks = 0;
  int nBad    = 0;

  // reference model state
  logic [15:0] mCmd;
  logic [31:4] mBase;
  logic [31:0] mIo [4];

  always #10 clk = ~clk;

  busTgtTop #(.VENDOR_ID(VEN), .DEVICE_ID(DEV)) i_busTgtTop (
    .clk(clk), .rstN(rstN), .frameN(frameN), .irdyN(irdyN), .idSel(idSel),
    .cbeN(cbeN), .adIn(adIn), .waitIn(waitIn), .stopReq(stopReq),
    .adOut(adOut), .adOe(adOe), .devselN(devselN), .trdyN(trdyN),
    .stopN(stopN), .ctlOe(ctlOe)
  );

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] mRead(input bit cfg, input int i);
    if (!cfg) return mIo[i & 3];
    case (i)
      0:       return {DEV, VEN};
      1:       return {16'h0000, mCmd};
      4:       return {mBase, 4'b0001};
      default: return 32'h0;
    endcase
  endfunction

  function automatic logic [31:0] mMerge(input logic [31:0] o, input logic [31:0] n,
                                         input logic [3:0] enN);
    logic [31:0] r;
    for (int b = 0; b < 4; b++) r[b*8 +: 8] = enN[b] ? o[b*8 +: 8] : n[b*8 +: 8];
    return r;
  endfunction

  task automatic mWrite(input bit cfg, input int i, input logic [31:0] d, input logic [3:0] be);
    logic [31:0] m;
    m = mMerge(mRead(cfg, i), d, be);
    if (!cfg) mIo[i & 3] = m;
    else if (i == 1) mCmd = m[15:0];
    else if (i == 4) mBase = m[31:4];
  endtask

  // One transaction from the initiator's side, checked clock by clock.
  // stopAfter < 0: no stop request; otherwise raised once that many words moved.
  task automatic txn(input logic [3:0] cmd, input logic [31:0] addr, input bit sel,
                     input int n, input logic [3:0] be, input logic [31:0] wBase,
                     input int waitCyc, input int irdyDelay, input int stopAfter,
                     input bit claim, input string req,
                     output int moved, output bit stopSeen);
    bit cfg, rd, last, holdPrev;
    int idx;
    logic [31:0] wd;
    cfg = cmd[3];
    rd  = !cmd[0];
    idx = cfg ? int'(addr[7:2]) : int'(addr[3:2]);
    moved = 0; stopSeen = 0; holdPrev = 0;
    frameN = 0; irdyN = 1; adIn = addr; cbeN = cmd; idSel = sel;
    waitIn = 0; stopReq = 0;
    tick();
    chk(req, "devsel after address", devselN, !claim);
    chk("R12", "no drive in turnaround", adOe, 0);
    idSel = 0;
    if (!claim) begin
      for (int c = 0; c < 4; c++) begin
        frameN = (c == 3); irdyN = 0; cbeN = be; adIn = wBase;
        tick();
        chk(req, "silent target", {devselN, ctlOe, adOe}, 3'b100);
      end
      frameN = 1; irdyN = 1;
      tick();
      chk(req, "silent after abort", {devselN, ctlOe, adOe}, 3'b100);
      return;
    end
    for (int cyc = 0; cyc < 40; cyc++) begin
      chk(req, "devsel held", devselN, 0);
      if (cyc >= 1) chk("R12", "read drive", adOe, rd);
      if (waitCyc > 0 && cyc <= waitCyc) chk("R5", "wait holds trdy", trdyN, 1);
      if (holdPrev) chk("R4", "trdy kept while irdy high", trdyN, 0);
      wd = wBase + moved * 32'h0101_0101;
      last = 0;
      if (!stopN) begin
        stopSeen = 1;
        chk("R9", "stop without ready", trdyN, 1);
        frameN = 1; irdyN = 0; last = 1;
      end else begin
        frameN = (moved >= n - 1);
        irdyN  = (cyc < irdyDelay);
        holdPrev = !trdyN && irdyN;
        if (!irdyN && !trdyN) begin
          if (rd) chk(req, "read data", adOut, mRead(cfg, idx));
          else    mWrite(cfg, idx, wd, be);
          moved++; idx++;
          last = frameN;
        end
      end
      adIn = wd; cbeN = be;
      waitIn  = (cyc < waitCyc);
      stopReq = (stopAfter >= 0) && (moved >= stopAfter);
      tick();
      if (last) begin
        chk("R8", "release drive", {devselN, trdyN, stopN, ctlOe, adOe}, 5'b11110);
        frameN = 1; irdyN = 1; stopReq = 0; waitIn = 0;
        tick();
        chk("R8", "control released", ctlOe, 0);
        return;
      end
    end
    chk(req, "transfer ended", 0, 1);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    nBad++;
    $display("FAIL R1 watchdog act=running exp=finished");
    $display("test done: total=%0d bad=%0d", nChecks, nBad);
    $finish;
  end

  initial begin
    int mv;
    bit st;
    mCmd = '0; mBase = '0;
    for (int i = 0; i < 4; i++) mIo[i] = '0;
    rstN = 0; frameN = 1; irdyN = 1; idSel = 0; cbeN = 4'hF; adIn = '0;
    waitIn = 0; stopReq = 0;
    repeat (3) tick();
    chk("R1", "reset outputs", {devselN, trdyN, stopN, ctlOe, adOe}, 5'b11100);
    rstN = 1;
    tick();
    chk("R1", "after reset", {devselN, trdyN, stopN, ctlOe, adOe}, 5'b11100);

    // R11 identity and command dwords
    txn(4'b1010, 32'h0000_0000, 1, 2, 4'h0, 0, 0, 0, -1, 1, "R11", mv, st);
    chk("R7", "config burst count", mv, 2);
    // R3 select low, misaligned low bits
    txn(4'b1010, 32'h0000_0000, 0, 1, 4'h0, 0, 0, 0, -1, 0, "R3", mv, st);
    txn(4'b1010, 32'h0000_0001, 1, 1, 4'h0, 0, 0, 0, -1, 0, "R3", mv, st);
    // R13 I/O access to base 0 with enable clear
    txn(4'b0011, 32'h0000_0000, 0, 1, 4'h0, 32'h5555_5555, 0, 0, -1, 0, "R13", mv, st);

    // R11 program base and command
    txn(4'b1011, 32'h0000_0010, 1, 1, 4'h0, 32'h0000_1235, 0, 0, -1, 1, "R11", mv, st);
    txn(4'b1011, 32'h0000_0004, 1, 1, 4'h0, 32'hFFFF_0001, 0, 0, -1, 1, "R11", mv, st);
    txn(4'b1010, 32'h0000_0010, 1, 1, 4'h0, 0, 0, 0, -1, 1, "R11", mv, st);
    txn(4'b1010, 32'h0000_0004, 1, 1, 4'h0, 0, 0, 0, -1, 1, "R11", mv, st);
    txn(4'b1010, 32'h0000_0024, 1, 1, 4'h0, 0, 0, 0, -1, 1, "R11", mv, st);

    // R2 / R7 write then read the window
    txn(4'b0011, 32'h0000_1230, 0, 4, 4'h0, 32'h1122_3344, 0, 0, -1, 1, "R7", mv, st);
    chk("R7", "write burst count", mv, 4);
    txn(4'b0010, 32'h0000_1230, 0, 4, 4'h0, 0, 0, 0, -1, 1, "R7", mv, st);
    chk("R7", "read burst count", mv, 4);
    txn(4'b0010, 32'h0000_1240, 0, 1, 4'h0, 0, 0, 0, -1, 0, "R2", mv, st);
    txn(4'b0010, 32'h0000_1233, 0, 1, 4'h0, 0, 0, 0, -1, 1, "R2", mv, st);

    // R6 partial byte write
    txn(4'b0011, 32'h0000_1234, 0, 1, 4'b1010, 32'hAABB_CCDD, 0, 0, -1, 1, "R6", mv, st);
    txn(4'b0010, 32'h0000_1234, 0, 1, 4'h0, 0, 0, 0, -1, 1, "R6", mv, st);

    // R10 burst running off the window end
    txn(4'b0011, 32'h0000_123C, 0, 3, 4'h0, 32'h9000_0001, 0, 0, -1, 1, "R10", mv, st);
    chk("R10", "words before disconnect", mv, 1);
    chk("R10", "stop seen", st, 1);
    txn(4'b0010, 32'h0000_123C, 0, 1, 4'h0, 0, 0, 0, -1, 1, "R10", mv, st);

    // R9 retry: no data
    txn(4'b0011, 32'h0000_1238, 0, 2, 4'h0, 32'hDEAD_0000, 0, 0, 0, 1, "R9", mv, st);
    chk("R9", "retry words", mv, 0);
    chk("R9", "retry stop", st, 1);
    txn(4'b0010, 32'h0000_1238, 0, 1, 4'h0, 0, 0, 0, -1, 1, "R9", mv, st);
    // R9 disconnect after one word
    txn(4'b0011, 32'h0000_1230, 0, 4, 4'h0, 32'h0BAD_F00D, 0, 0, 1, 1, "R9", mv, st);
    chk("R9", "disconnect words", mv, 1);
    chk("R9", "disconnect stop", st, 1);
    txn(4'b0010, 32'h0000_1230, 0, 2, 4'h0, 0, 0, 0, -1, 1, "R9", mv, st);

    // R5 target wait states, R4 initiator stalls
    txn(4'b0010, 32'h0000_1230, 0, 2, 4'h0, 0, 3, 0, -1, 1, "R5", mv, st);
    chk("R5", "words with waits", mv, 2);
    txn(4'b0010, 32'h0000_1234, 0, 1, 4'h0, 0, 0, 4, -1, 1, "R4", mv, st);
    chk("R4", "words with stall", mv, 1);
    txn(4'b0011, 32'h0000_1238, 0, 2, 4'h0, 32'h7777_0000, 2, 3, -1, 1, "R4", mv, st);
    txn(4'b0010, 32'h0000_1238, 0, 2, 4'h0, 0, 0, 0, -1, 1, "R4", mv, st);

    $display("test done: total=%0d bad=%0d", nChecks, nBad);
    $finish;
  end

endmodule